// File: doc/BRIEF.md
# Sub-band AFC controller with relock monitor

This block picks the sub-band of a multi-band VCO and then keeps watch on the loop's control voltages. When calibration is launched, it runs a successive-approximation search over the band code. For each trial band it opens a counting window of a programmable number of reference cycles. At the end of the window it compares the divided-VCO count for that window against a target count. A count above the target means the trial band is too fast, so the trial bit is cleared. After one window per code bit, the band is final and the block reports calibration done.

Once the band is final, the block waits a settling interval so the synthesizer can lock. The interval is a parameter counted in reference cycles; 80 µs is the intended setting. After that interval, a lock monitor is armed. The monitor takes four "inside window" flags, one per threshold (high and low) on each of the two differential control lines, and passes them through a two-flop synchronizer. It then combines them in NAND fashion. If any flag shows a line outside its window, the block does not step the band. It restarts the whole search from the midpoint code, emits a one-cycle relock pulse and increments a saturating relock counter.

The external frequency counter is cleared at the start of every window through a strobe, and it supplies its count back to the block. The reference clock is the block clock.

Top module: `afc_relock_ctrl`

## Requirements
- R1: A synchronous active-high reset gives band code 0, done low, relock pulse low and relock count 0, with the block idle and the monitor disarmed.
- R2: A start pulse in idle loads the band code with only its MSB set (8 for 4 bits). The search then takes exactly BAND_W windows. Done rises BAND_W × window cycles after the edge that samples start.
- R3: At the end of each window, a divided count strictly greater than the target clears the trial bit, and the next lower bit is then set. The final code is therefore the largest code whose count does not exceed the target, or 0 if none does.
- R4: Each window lasts win_cycles reference cycles, with a value of 0 treated as 1. The count-clear strobe is high on the first cycle of each window, so it is seen BAND_W times per calibration.
- R5: Done stays high and the band code stays frozen after calibration. For SETTLE_CYC cycles after done rises, flags outside the window cause no relock. With a flag already bad, the relock pulse comes SETTLE_CYC+1 cycles after done rises.
- R6: While the monitor is armed, any one of the four inside-window flags going low causes a relock pulse exactly one cycle long.
- R7: A relock drops done, reloads the band code with the MSB-only value, and reruns the full search. The search arrives at the same band for the same target.
- R8: The relock counter increments by one per relock and saturates at its all-ones value.
- R9: During calibration (idle and search), flag values have no effect: they cause no relock pulse and no change to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the first calibration from idle |
| ctl_in_win | input | 4 | Inside-window flags: [0] line P above low, [1] line P below high, [2] line N above low, [3] line N below high |
| win_cycles | input | CNT_W | Counting window length in reference cycles |
| target_cnt | input | CNT_W | Expected divided count per window |
| vco_count | input | CNT_W | Divided-VCO count over the current window |
| meas_clear | output | 1 | Clear strobe for the external counter, first cycle of each window |
| band_code | output | BAND_W | Selected VCO sub-band |
| cal_done | output | 1 | Calibration finished (settling or monitoring) |
| relock_pulse | output | 1 | One-cycle pulse when loss of lock restarts calibration |
| relock_count | output | RCNT_W | Saturating count of relocks |

## Verification
On every cycle, the assertions check the following: the relock pulse is a single cycle long; every relock coincides with done low and the MSB-only band code; the relock counter never decreases; the band code cannot move while done is held; the trial mask stays one-hot or empty. Only the bench scenarios can show the resulting band for a given target. They also show the exact window and settling durations, that the monitor is blind during search and settling, that a single bad line is enough to relock, and that the counter saturates after repeated loss of lock.

// File: rtl/afc_pkg.sv
package afc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WATCH  = 2'd3
    } afc_state_e;

    typedef struct packed {
        logic load;   // reload band with midpoint code
        logic step;   // apply one search decision
        logic clr;    // restart the shared cycle timer
    } afc_ctl_t;

    function automatic logic over_target(input logic [31:0] cnt, input logic [31:0] tgt);
        return cnt > tgt;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/afc_sar.sv
module afc_sar #(
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              too_fast,
    output logic [BAND_W-1:0] band,
    output logic              last
);
    localparam logic [BAND_W-1:0] MID_CODE = {1'b1, {(BAND_W-1){1'b0}}};

    logic [BAND_W-1:0] trial_q;
    logic [BAND_W-1:0] band_nx;

    always_comb begin
        band_nx = band;
        if (too_fast) band_nx = band_nx & ~trial_q;
        band_nx = band_nx | (trial_q >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            band    <= '0;
            trial_q <= '0;
        end else if (load) begin
            band    <= MID_CODE;
            trial_q <= MID_CODE;
        end else if (step) begin
            band    <= band_nx;
            trial_q <= trial_q >> 1;
        end
    end

    assign last = trial_q[0];

    AST_TRIAL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trial_q)); // R2
    AST_LOAD_MIDPOINT: assert property (@(posedge clk) disable iff (rst)
        load |=> (band == MID_CODE)); // R2

endmodule

// File: rtl/afc_cycle_timer.sv
module afc_cycle_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)       count <= '0;
        else if (count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/afc_lock_monitor.sv
module afc_lock_monitor #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [LINES-1:0] in_win,
    output logic             trip
);
    logic [LINES-1:0] sync1_q;
    logic [LINES-1:0] sync2_q;

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync1_q[g] <= 1'b1;
                sync2_q[g] <= 1'b1;
            end else begin
                sync1_q[g] <= in_win[g];
                sync2_q[g] <= sync1_q[g];
            end
        end
    end

    // NAND of all inside-window flags: high when any line has left its window
    assign trip = arm & ~(&sync2_q);

    AST_TRIP_NEEDS_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        trip |-> !(&$past(in_win, 2))); // R6

endmodule

// File: rtl/afc_relock_ctrl.sv
module afc_relock_ctrl
    import afc_pkg::*;
#(
    parameter int BAND_W     = 4,
    parameter int CNT_W      = 12,
    parameter int SETTLE_CYC = 3200,
    parameter int RCNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        ctl_in_win,
    input  logic [CNT_W-1:0]  win_cycles,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic [CNT_W-1:0]  vco_count,
    output logic              meas_clear,
    output logic [BAND_W-1:0] band_code,
    output logic              cal_done,
    output logic              relock_pulse,
    output logic [RCNT_W-1:0] relock_count
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int TMR_W = max_int(CNT_W, SET_W);
    localparam logic [TMR_W-1:0]  SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
    localparam logic [BAND_W-1:0] MID_CODE    = {1'b1, {(BAND_W-1){1'b0}}};

    afc_state_e       state_q, state_d;
    afc_ctl_t         ctl;
    logic [TMR_W-1:0] tmr_cnt;
    logic [TMR_W:0]   tmr_next;
    logic [TMR_W:0]   win_ext;
    logic             win_last, settle_last, too_fast, sar_last, trip;

    assign tmr_next    = {1'b0, tmr_cnt} + 1'b1;
    assign win_ext     = {{(TMR_W + 1 - CNT_W){1'b0}}, win_cycles};
    assign win_last    = tmr_next >= win_ext;       // 0 behaves as 1
    assign settle_last = (tmr_cnt == SETTLE_LAST);
    assign too_fast    = over_target(32'(vco_count), 32'(target_cnt));

    always_comb begin
        state_d  = state_q;
        ctl      = '0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_SEARCH;
                ctl.load = 1'b1;
            end
            ST_SEARCH: if (win_last) begin
                ctl.step = 1'b1;
                ctl.clr  = 1'b1;
                if (sar_last) state_d = ST_SETTLE;
            end
            ST_SETTLE: if (settle_last) state_d = ST_WATCH;
            ST_WATCH: if (trip) begin
                state_d  = ST_SEARCH;
                ctl.load = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d != state_q) ctl.clr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            relock_pulse <= 1'b0;
            relock_count <= '0;
        end else begin
            state_q      <= state_d;
            relock_pulse <= (state_q == ST_WATCH) && trip;
            if ((state_q == ST_WATCH) && trip && (relock_count != '1))
                relock_count <= relock_count + 1'b1;
        end
    end

    afc_sar #(.BAND_W(BAND_W)) sar_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.step),
        .too_fast (too_fast),
        .band     (band_code),
        .last     (sar_last)
    );

    afc_cycle_timer #(.W(TMR_W)) tmr_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctl.clr),
        .count (tmr_cnt)
    );

    afc_lock_monitor #(.LINES(4)) mon_i (
        .clk    (clk),
        .rst    (rst),
        .arm    (state_q == ST_WATCH),
        .in_win (ctl_in_win),
        .trip   (trip)
    );

    assign meas_clear = (state_q == ST_SEARCH) && (tmr_cnt == '0);
    assign cal_done   = (state_q == ST_SETTLE) || (state_q == ST_WATCH);

    AST_RELOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        relock_pulse |=> !relock_pulse); // R6
    AST_RELOCK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        relock_pulse |-> (band_code == MID_CODE) && !cal_done); // R7
    AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> relock_count >= $past(relock_count)); // R8
    AST_BAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cal_done && $past(cal_done)) |-> $stable(band_code)); // R5
    AST_RELOCK_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        relock_pulse |-> $past(state_q == ST_WATCH)); // R9

endmodule

// File: tb/afc_relock_ctrl_tb_top.sv
module afc_relock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 4;
    localparam int CW = 12;
    localparam int SC = 20;
    localparam int RW = 2;
    localparam int NVEC = 8;
    // {target[27:16], window[15:4], expected band[3:0]} with count = 100 + 10*band
    localparam logic [27:0] VEC [0:NVEC-1] = '{
        {12'd95,  12'd1, 4'd0},
        {12'd100, 12'd2, 4'd0},
        {12'd155, 12'd3, 4'd5},
        {12'd160, 12'd5, 4'd6},
        {12'd249, 12'd0, 4'd14},
        {12'd250, 12'd4, 4'd15},
        {12'd400, 12'd2, 4'd15},
        {12'd133, 12'd7, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst, start;
    logic [3:0]    ctl_in_win;
    logic [CW-1:0] win_cycles, target_cnt, vco_count;
    logic          meas_clear, cal_done, relock_pulse;
    logic [BW-1:0] band_code;
    logic [RW-1:0] relock_count;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    assign vco_count = CW'(100 + 10 * int'(band_code));

    afc_relock_ctrl #(.BAND_W(BW), .CNT_W(CW), .SETTLE_CYC(SC), .RCNT_W(RW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ctl_in_win(ctl_in_win),
        .win_cycles(win_cycles), .target_cnt(target_cnt), .vco_count(vco_count),
        .meas_clear(meas_clear), .band_code(band_code), .cal_done(cal_done),
        .relock_pulse(relock_pulse), .relock_count(relock_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        check(band_code == 0, "R1 band", band_code, 0);
        check(!cal_done && !relock_pulse, "R1 done/pulse", {cal_done, relock_pulse}, 0);
        check(relock_count == 0, "R1 count", relock_count, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cal(output int cyc, output int clears, output int first_band);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_band = band_code;
        cyc = 0;
        clears = meas_clear ? 1 : 0;
        while (!cal_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (meas_clear && !cal_done) clears++;
        end
    endtask

    // waits through a calibration that was started by a relock
    task automatic wait_done(output int cyc, output int pulses);
        cyc = 0; pulses = 0;
        while (!cal_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (relock_pulse) pulses++;
        end
    endtask

    task automatic wait_relock(output int c);
        c = 0;
        while (!relock_pulse && c < 5000) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cyc, clr, fb, c, pl, wexp;
        rst = 1'b1; start = 1'b0; ctl_in_win = 4'hF;
        win_cycles = CW'(2); target_cnt = CW'(155);

        // Table walk: reset, calibrate, compare band and timing
        for (int i = 0; i < NVEC; i++) begin
            target_cnt = VEC[i][27:16];
            win_cycles = VEC[i][15:4];
            wexp = (VEC[i][15:4] == 0) ? 1 : int'(VEC[i][15:4]);
            do_reset();
            run_cal(cyc, clr, fb);
            check(fb == 8, "R2 first trial code", fb, 8);
            check(cyc == BW * wexp, "R2/R4 calibration length", cyc, BW * wexp);
            check(clr == BW, "R4 clear strobes", clr, BW);
            check(band_code == VEC[i][3:0], "R3 final band", band_code, VEC[i][3:0]);
        end

        // Settling guard and single-line loss of lock
        target_cnt = CW'(155); win_cycles = CW'(2);
        do_reset();
        run_cal(cyc, clr, fb);
        ctl_in_win = 4'b1011;              // line N low threshold only
        wait_relock(c);
        check(c == SC + 1, "R5 settle then relock delay", c, SC + 1);
        check(relock_count == 1, "R8 count after first relock", relock_count, 1);
        check(band_code == 8, "R7 band reloaded", band_code, 8);
        check(!cal_done, "R7 done dropped", cal_done, 0);
        ctl_in_win = 4'h0;                 // bad flags during search
        @(negedge clk);
        check(!relock_pulse, "R6 single-cycle pulse", relock_pulse, 0);
        repeat (4) @(negedge clk);
        ctl_in_win = 4'hF;
        wait_done(cyc, pl);
        check(pl == 0, "R9 no relock during search", pl, 0);
        check(relock_count == 1, "R9 count unchanged", relock_count, 1);
        check(band_code == 5, "R7 same band after recal", band_code, 5);

        // Hold band with good flags: done stays high, no relock
        repeat (SC + 10) @(negedge clk);
        check(cal_done && !relock_pulse, "R5 done held", {cal_done, relock_pulse}, 2);
        check(band_code == 5, "R5 band frozen", band_code, 5);

        // Repeated loss of lock: counter saturates
        for (int k = 0; k < 3; k++) begin
            ctl_in_win = (k == 0) ? 4'b1110 : 4'b0111;
            wait_relock(c);
            check(relock_pulse, "R6 relock seen", relock_pulse, 1);
            ctl_in_win = 4'hF;
            wait_done(cyc, pl);
        end
        check(relock_count == 3, "R8 saturated count", relock_count, 3);

        do_reset();
        summary();
    end
endmodule